// File: doc/BRIEF.md
# Flash Command and Status Controller

This block is the device-side control logic of a small parallel NOR-style flash. A host writes address/data pairs over a simple strobed bus. The block decodes multi-write unlock and command sequences from these writes. It then runs an abstracted embedded program or erase, whose duration is set by a cycle counter. The storage is a small on-chip register array. While an operation runs, the block drives a ready/busy output low. Data reads then return status, in which some bits change on every read strobe.

An erase can be suspended. While it is suspended, the other sectors can be read and programmed, and a later command resumes the erase. A pin selects whether the data path is 16 bits wide or 8 bits wide. In 8-bit mode the top data pin carries the lowest address bit.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst_n` is low, `ry_by` is 0. Within three clock cycles after release, `ry_by` is 1 and the block is in read mode. After reset every array word reads 0xFFFF, and the read toggle flag is 0.
- R2: A program is the writes 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0, then the target address and data. `ry_by` is 0 in the cycle after the fourth write edge and stays 0 for exactly PGM_CYC cycles. The stored word then becomes old AND new.
- R3: An erase is the writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then a sixth write. A sixth write of 0x30 at any address erases that address's sector. A sixth write of 0x10 at 0x555 erases all sectors. `ry_by` is 0 from the cycle after the sixth write for ERS_CYC cycles. Afterwards every word of the affected sectors reads 0xFFFF, and other words are unchanged.
- R4: A wrong address or data value at any step returns the decoder to idle. No memory word changes and `ry_by` stays 1. A new sequence must start from its first write.
- R5: While `ry_by` is 0, writes do not start, advance or count toward any command. The one exception is 0xB0 during an erase.
- R6: A write of 0xB0 at any address during an erase suspends it. `ry_by` is 1 from the next cycle and the erase countdown is frozen. In suspend, a single write of 0x30 resumes the erase. `ry_by` is then 0 for the cycles that remain.
- R7: An internal toggle flag inverts at every clock edge where `re` is 1. While a program runs (including one started inside suspend), a read returns 0x0000 except that bit 6 shows the flag and bit 2 is 1. While an erase runs, a read returns bit 6 equal to the flag. Bit 2 equals the flag if the addressed sector is being erased, and is 1 otherwise.
- R8: In suspend, a read from the suspended sector returns bit 6 = 1 and bit 2 = the flag, with all other bits 0. A read from any other sector returns array data. A program to another sector runs normally and returns to suspend. A program sequence aimed at the suspended sector is ignored.
- R9: With `word_mode` = 1, `rdata` is the whole word and `rdata_oe` is 0xFFFF. With `word_mode` = 0, `dq_in[15]` selects the byte (1 = upper byte), `rdata[7:0]` carries that byte, the upper byte is 0 and `rdata_oe` is 0x00FF. A byte program changes only the selected byte.
- R10: Command values are compared on `dq_in[7:0]` only, and command addresses on `addr` only. The upper data byte never affects decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| we | input | 1 | Write strobe, one write per cycle it is high |
| re | input | 1 | Read strobe, flips the status toggle flag |
| addr | input | AW | Word address; low bits index the array |
| dq_in | input | 16 | Write data; bit 15 is the byte select in 8-bit mode |
| word_mode | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| rdata | output | 16 | Read data or status |
| rdata_oe | output | 16 | Per-bit output enable of the data pins |
| ry_by | output | 1 | 1 = ready, 0 = busy or in reset |

## Verification
The bench builds the block with four sectors of eight words, a six-cycle program and a 24-cycle erase. With these values a chip erase leaves a 32-word model that the bench can compare in full. The short program time lets the bench count every busy window cycle by cycle. The erase is long enough to hold status reads, a complete ignored program sequence, a suspend and the frozen-count arithmetic behind the resume check.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;
  typedef enum logic [2:0] {
    OP_READ, OP_PGM, OP_ERASE, OP_SUSP, OP_SUSP_PGM
  } op_e;

  typedef enum logic [2:0] {
    CS_IDLE, CS_U1, CS_U2, CS_PGM, CS_E1, CS_E2, CS_E3
  } cs_e;

  localparam logic [7:0] KEY_A       = 8'hAA;
  localparam logic [7:0] KEY_B       = 8'h55;
  localparam logic [7:0] CMD_PGM     = 8'hA0;
  localparam logic [7:0] CMD_ERS     = 8'h80;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;
endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
  import flash_ctrl_pkg::*;
#(
  parameter int AW    = 11,
  parameter int IDX_W = 6,
  parameter int SW_W  = 4,
  localparam int SEC_W = IDX_W - SW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       d8,
  input  op_e              op,
  input  logic [SEC_W-1:0] ers_sect,
  input  logic             ers_chip,
  output logic             start_pgm,
  output logic             start_erase,
  output logic             erase_chip,
  output logic             suspend_req,
  output logic             resume_req,
  output cs_e              cs_o
);
  cs_e cs_q, cs_d;
  logic at_a, at_b, in_susp_sect;

  assign at_a = (addr == AW'(11'h555));
  assign at_b = (addr == AW'(11'h2AA));
  assign in_susp_sect = ers_chip || (addr[IDX_W-1:SW_W] == ers_sect);
  assign cs_o = cs_q;

  always_comb begin
    cs_d        = cs_q;
    start_pgm   = 1'b0;
    start_erase = 1'b0;
    erase_chip  = 1'b0;
    suspend_req = 1'b0;
    resume_req  = 1'b0;
    if (we) begin
      cs_d = CS_IDLE;
      if (op == OP_ERASE) begin
        suspend_req = (d8 == CMD_SUSPEND);
      end else if (op == OP_READ || op == OP_SUSP) begin
        unique case (cs_q)
          CS_IDLE: begin
            if (at_a && d8 == KEY_A) cs_d = CS_U1;
            else if (op == OP_SUSP && d8 == CMD_RESUME) resume_req = 1'b1;
          end
          CS_U1: if (at_b && d8 == KEY_B) cs_d = CS_U2;
          CS_U2: begin
            if (at_a && d8 == CMD_PGM) cs_d = CS_PGM;
            else if (at_a && d8 == CMD_ERS && op == OP_READ) cs_d = CS_E1;
          end
          CS_PGM: start_pgm = !(op == OP_SUSP && in_susp_sect);
          CS_E1: if (at_a && d8 == KEY_A) cs_d = CS_E2;
          CS_E2: if (at_b && d8 == KEY_B) cs_d = CS_E3;
          CS_E3: begin
            if (d8 == CMD_SECT) start_erase = 1'b1;
            else if (at_a && d8 == CMD_CHIP) begin
              start_erase = 1'b1;
              erase_chip  = 1'b1;
            end
          end
          default: cs_d = CS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= CS_IDLE;
    else if (we) cs_q <= cs_d;
  end
endmodule

// File: rtl/fcc_seq.sv
module fcc_seq
  import flash_ctrl_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int SW_W    = 4,
  parameter int PGM_CYC = 16,
  parameter int ERS_CYC = 64,
  localparam int SEC_W  = IDX_W - SW_W,
  localparam int CW     = $clog2((PGM_CYC > ERS_CYC ? PGM_CYC : ERS_CYC) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pgm,
  input  logic             start_erase,
  input  logic             erase_chip,
  input  logic             suspend_req,
  input  logic             resume_req,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      dq,
  input  logic             word_mode,
  output op_e              op,
  output logic             busy,
  output logic             pgm_commit,
  output logic [IDX_W-1:0] pgm_idx,
  output logic [15:0]      pgm_pat,
  output logic             ers_commit,
  output logic [SEC_W-1:0] ers_sect,
  output logic             ers_chip
);
  op_e op_q, op_d;
  logic [CW-1:0] pcnt_q, pcnt_d, ecnt_q, ecnt_d;
  logic [15:0] pat_in;

  assign pat_in = word_mode ? dq : (dq[15] ? {dq[7:0], 8'hFF} : {8'hFF, dq[7:0]});

  always_comb begin
    op_d = op_q;
    pcnt_d = pcnt_q;
    ecnt_d = ecnt_q;
    pgm_commit = 1'b0;
    ers_commit = 1'b0;
    unique case (op_q)
      OP_READ: begin
        if (start_pgm) begin
          op_d = OP_PGM; pcnt_d = CW'(PGM_CYC - 1);
        end else if (start_erase) begin
          op_d = OP_ERASE; ecnt_d = CW'(ERS_CYC - 1);
        end
      end
      OP_PGM, OP_SUSP_PGM: begin
        if (pcnt_q == '0) begin
          pgm_commit = 1'b1;
          op_d = (op_q == OP_PGM) ? OP_READ : OP_SUSP;
        end else pcnt_d = pcnt_q - 1'b1;
      end
      OP_ERASE: begin
        if (suspend_req) op_d = OP_SUSP;
        else if (ecnt_q == '0) begin
          ers_commit = 1'b1; op_d = OP_READ;
        end else ecnt_d = ecnt_q - 1'b1;
      end
      OP_SUSP: begin
        if (start_pgm) begin
          op_d = OP_SUSP_PGM; pcnt_d = CW'(PGM_CYC - 1);
        end else if (resume_req) op_d = OP_ERASE;
      end
      default: op_d = OP_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_READ; pcnt_q <= '0; ecnt_q <= '0;
    end else begin
      op_q <= op_d; pcnt_q <= pcnt_d; ecnt_q <= ecnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_idx <= '0; pgm_pat <= '1;
    end else if (start_pgm) begin
      pgm_idx <= idx; pgm_pat <= pat_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ers_sect <= '0; ers_chip <= 1'b0;
    end else if (start_erase) begin
      ers_sect <= idx[IDX_W-1:SW_W]; ers_chip <= erase_chip;
    end
  end

  assign op   = op_q;
  assign busy = (op_q == OP_PGM) || (op_q == OP_ERASE) || (op_q == OP_SUSP_PGM);
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int NSECT      = 4,
  parameter int SECT_WORDS = 16,
  localparam int DEPTH = NSECT * SECT_WORDS,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SW_W  = $clog2(SECT_WORDS),
  localparam int SEC_W = IDX_W - SW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pgm_commit,
  input  logic [IDX_W-1:0] pgm_idx,
  input  logic [15:0]      pgm_pat,
  input  logic             ers_commit,
  input  logic [SEC_W-1:0] ers_sect,
  input  logic             ers_chip,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_word
);
  logic [15:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [SEC_W-1:0] SI = SEC_W'(i / SECT_WORDS);
    logic [15:0] word_q;
    logic hit_e, hit_p;
    assign hit_e = ers_commit && (ers_chip || ers_sect == SI);
    assign hit_p = pgm_commit && (pgm_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '1;
      else if (hit_e) word_q <= '1;
      else if (hit_p) word_q <= word_q & pgm_pat;
    end
    assign words[i] = word_q;
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int AW         = 11,
  parameter int NSECT      = 4,
  parameter int SECT_WORDS = 16,
  parameter int PGM_CYC    = 16,
  parameter int ERS_CYC    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  input  logic          word_mode,
  output logic [15:0]   rdata,
  output logic [15:0]   rdata_oe,
  output logic          ry_by
);
  localparam int DEPTH = NSECT * SECT_WORDS;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SW_W  = $clog2(SECT_WORDS);
  localparam int SEC_W = IDX_W - SW_W;

  logic [1:0] rs_q;
  logic rst_i_n, tog_q;
  op_e op_w;
  cs_e cs_w;
  logic start_pgm, start_erase, erase_chip, suspend_req, resume_req;
  logic busy, pgm_commit, ers_commit, ers_chip, lane, in_ers, is_stat;
  logic [IDX_W-1:0] pgm_idx, idx;
  logic [15:0] pgm_pat, rd_word, data16;
  logic [SEC_W-1:0] ers_sect;
  logic [7:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) tog_q <= 1'b0;
    else if (re) tog_q <= ~tog_q;
  end

  assign idx = addr[IDX_W-1:0];

  fcc_decode #(.AW(AW), .IDX_W(IDX_W), .SW_W(SW_W)) u_dec (
    .clk(clk), .rst_n(rst_i_n), .we(we), .addr(addr), .d8(dq_in[7:0]),
    .op(op_w), .ers_sect(ers_sect), .ers_chip(ers_chip),
    .start_pgm(start_pgm), .start_erase(start_erase), .erase_chip(erase_chip),
    .suspend_req(suspend_req), .resume_req(resume_req), .cs_o(cs_w)
  );

  fcc_seq #(.IDX_W(IDX_W), .SW_W(SW_W), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .start_pgm(start_pgm), .start_erase(start_erase),
    .erase_chip(erase_chip), .suspend_req(suspend_req), .resume_req(resume_req),
    .idx(idx), .dq(dq_in), .word_mode(word_mode), .op(op_w), .busy(busy),
    .pgm_commit(pgm_commit), .pgm_idx(pgm_idx), .pgm_pat(pgm_pat),
    .ers_commit(ers_commit), .ers_sect(ers_sect), .ers_chip(ers_chip)
  );

  fcc_array #(.NSECT(NSECT), .SECT_WORDS(SECT_WORDS)) u_arr (
    .clk(clk), .rst_n(rst_i_n), .pgm_commit(pgm_commit), .pgm_idx(pgm_idx),
    .pgm_pat(pgm_pat), .ers_commit(ers_commit), .ers_sect(ers_sect),
    .ers_chip(ers_chip), .rd_idx(idx), .rd_word(rd_word)
  );

  assign lane   = !word_mode && dq_in[15];
  assign in_ers = ers_chip || (idx[IDX_W-1:SW_W] == ers_sect);

  always_comb begin
    data16  = word_mode ? rd_word : {8'h00, lane ? rd_word[15:8] : rd_word[7:0]};
    st      = 8'h00;
    is_stat = 1'b0;
    unique case (op_w)
      OP_PGM, OP_SUSP_PGM: begin
        is_stat = 1'b1; st[6] = tog_q; st[2] = 1'b1;
      end
      OP_ERASE: begin
        is_stat = 1'b1; st[6] = tog_q; st[2] = in_ers ? tog_q : 1'b1;
      end
      OP_SUSP: if (in_ers) begin
        is_stat = 1'b1; st[6] = 1'b1; st[2] = tog_q;
      end
      default: ;
    endcase
    rdata = is_stat ? {8'h00, st} : data16;
  end

  assign rdata_oe = word_mode ? 16'hFFFF : 16'h00FF;
  assign ry_by    = rst_i_n & ~busy;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
  import flash_ctrl_pkg::*;
(
  input logic       clk,
  input logic       rst_i_n,
  input logic       we,
  input logic       re,
  input logic [7:0] dq_lo,
  input op_e        op,
  input cs_e        cs,
  input logic       ry_by,
  input logic       rdata6
);
  AST_PGM_START_BUSY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (we && cs == CS_PGM && op == OP_READ) |=> !ry_by); // R2

  AST_ERASE_START_BUSY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (we && cs == CS_E3 && dq_lo == 8'h30 && op == OP_READ) |=> !ry_by); // R3

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (we && op == OP_PGM) |=> (cs == CS_IDLE)); // R5

  AST_SUSPEND_READY: assert property (@(posedge clk) disable iff (!rst_i_n)
    (we && op == OP_ERASE && dq_lo == 8'hB0) |=> ry_by); // R6

  AST_STATUS_TOGGLES: assert property (@(posedge clk) disable iff (!rst_i_n)
    (re && op == OP_PGM && $past(re && op == OP_PGM)) |-> (rdata6 != $past(rdata6))); // R7
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_i_n(rst_i_n), .we(we), .re(re), .dq_lo(dq_in[7:0]),
  .op(op_w), .cs(cs_w), .ry_by(ry_by), .rdata6(rdata[6])
);

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int AW = 11, NSECT = 4, SW = 8, PGM = 6, ERS = 24;
  localparam int DEPTH = NSECT * SW;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0, word_mode = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq = '0;
  logic [15:0] rdata, rdata_oe;
  logic ry_by;

  logic [15:0] mem_m [DEPTH];
  bit tog_m = 1'b0;
  int cyc = 0, n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  flash_cmd_ctrl #(.AW(AW), .NSECT(NSECT), .SECT_WORDS(SW), .PGM_CYC(PGM), .ERS_CYC(ERS))
    u_flash_cmd_ctrl (.clk(clk), .rst_n(rst_n), .we(we), .re(re), .addr(addr),
      .dq_in(dq), .word_mode(word_mode), .rdata(rdata), .rdata_oe(rdata_oe), .ry_by(ry_by));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] stat(input bit b6, input bit b2);
    return {8'h00, 1'b0, b6, 3'b000, b2, 2'b00};
  endfunction

  function automatic logic [15:0] exp_rd(input int idx, input bit wm, input bit lane);
    if (wm) return mem_m[idx];
    return {8'h00, lane ? mem_m[idx][15:8] : mem_m[idx][7:0]};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; dq = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int idx, input bit lane, output logic [15:0] v, output logic [15:0] oe);
    @(negedge clk); re = 1'b1; addr = AW'(idx); dq[15] = lane;
    #1; v = rdata; oe = rdata_oe;
    @(negedge clk); re = 1'b0; tog_m = ~tog_m;
  endtask

  task automatic wait_ready(input int c0, output int n);
    while (ry_by !== 1'b1) @(negedge clk);
    n = cyc - c0;
  endtask

  task automatic unlock3(input logic [7:0] cmd);
    wr(11'h555, {8'($urandom), 8'hAA});   // R10 upper byte random
    wr(11'h2AA, {8'($urandom), 8'h55});
    wr(11'h555, {8'($urandom), cmd});
  endtask

  task automatic do_pgm(input int idx, input logic [15:0] d, input bit wm, input bit lane,
                        input bit wait_it, output int c0);
    logic [15:0] pat;
    int n;
    word_mode = wm;
    unlock3(8'hA0);
    wr(AW'(idx), wm ? d : {lane, 7'($urandom), d[7:0]});
    c0 = cyc;
    chk(ry_by == 1'b0, "R2 busy after 4th write", 32'(ry_by), 0);
    pat = wm ? d : (lane ? {d[7:0], 8'hFF} : {8'hFF, d[7:0]});
    mem_m[idx] = mem_m[idx] & pat;
    if (wait_it) begin
      wait_ready(c0, n);
      chk(n == PGM, "R2 program busy length", 32'(n), 32'(PGM));
    end
  endtask

  task automatic do_erase(input int a, input bit chip, output int c0);
    word_mode = 1'b1;
    unlock3(8'h80);
    wr(11'h555, 16'h00AA);
    wr(11'h2AA, 16'h0055);
    if (chip) wr(11'h555, 16'h0010); else wr(AW'(a), 16'h0030);
    c0 = cyc;
    chk(ry_by == 1'b0, "R3 busy after 6th write", 32'(ry_by), 0);
  endtask

  initial begin
    logic [15:0] v, oe, e;
    int c0, cs, n, k, idx, sel, lane;
    bit wm;
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 16'hFFFF;
    void'($urandom(32'd2024));

    // R1 reset
    repeat (3) @(negedge clk);
    chk(ry_by == 1'b0, "R1 busy during reset", 32'(ry_by), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ry_by == 1'b1, "R1 ready after reset", 32'(ry_by), 1);
    rd(5, 0, v, oe);
    chk(v == 16'hFFFF, "R1 erased after reset", v, 16'hFFFF);
    chk(oe == 16'hFFFF, "R9 word oe", oe, 16'hFFFF);

    // R2 program and AND behaviour
    do_pgm(3, 16'h5A3C, 1, 0, 1, c0);
    do_pgm(3, 16'hF0F0, 1, 0, 1, c0);
    rd(3, 0, v, oe);
    chk(v == 16'h5030, "R2 program ANDs", v, 16'h5030);

    // R9 byte mode
    do_pgm(6, 16'h0012, 0, 1, 1, c0);
    word_mode = 1'b0;
    rd(6, 1, v, oe);
    chk(v == 16'h0012, "R9 byte read upper lane", v, 16'h0012);
    chk(oe == 16'h00FF, "R9 byte oe", oe, 16'h00FF);
    rd(6, 0, v, oe);
    chk(v == 16'h00FF, "R9 byte read lower lane", v, 16'h00FF);
    word_mode = 1'b1;
    rd(6, 0, v, oe);
    chk(v == 16'h12FF, "R9 byte program one lane only", v, 16'h12FF);

    // R4 broken sequences
    wr(11'h555, 16'h00AA); wr(11'h2AB, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd7, 16'h0000);
    chk(ry_by == 1'b1, "R4 bad address no start", 32'(ry_by), 1);
    wr(11'h555, 16'h00AA); wr(11'h2AA, 16'h0056); wr(11'h555, 16'h00A0); wr(11'd7, 16'h0000);
    chk(ry_by == 1'b1, "R4 bad data no start", 32'(ry_by), 1);
    rd(7, 0, v, oe);
    chk(v == 16'hFFFF, "R4 memory unchanged", v, 16'hFFFF);

    // R5 write during program busy does not count
    do_pgm(4, 16'h00FF, 1, 0, 0, c0);
    wr(11'h555, 16'h00AA);
    wait_ready(c0, n);
    wr(11'h2AA, 16'h0055); wr(11'h555, 16'h00A0); wr(11'd5, 16'h0000);
    chk(ry_by == 1'b1, "R5 unlock during busy ignored", 32'(ry_by), 1);
    rd(5, 0, v, oe);
    chk(v == 16'hFFFF, "R5 no program after busy", v, 16'hFFFF);

    // R7 status during program
    do_pgm(12, 16'h1111, 1, 0, 0, c0);
    for (int r = 0; r < 2; r++) begin
      e = stat(tog_m, 1'b1);
      rd(12, 0, v, oe);
      chk(v == e, "R7 program status", v, e);
    end
    wait_ready(c0, n);

    // R3 sector erase, R5 program sequence during erase ignored, R7 erase status
    do_pgm(9, 16'h0000, 1, 0, 1, c0);
    do_erase(10, 0, c0);
    e = stat(tog_m, tog_m);
    rd(9, 0, v, oe);
    chk(v == e, "R7 erase status same sector", v, e);
    e = stat(tog_m, 1'b1);
    rd(3, 0, v, oe);
    chk(v == e, "R7 erase status other sector", v, e);
    unlock3(8'hA0); wr(11'd20, 16'h0000);
    wait_ready(c0, n);
    chk(n == ERS, "R3 erase busy length", 32'(n), 32'(ERS));
    for (int i = 8; i < 16; i++) mem_m[i] = 16'hFFFF;
    rd(9, 0, v, oe);
    chk(v == 16'hFFFF, "R3 sector erased", v, 16'hFFFF);
    rd(3, 0, v, oe);
    chk(v == mem_m[3], "R3 other sector kept", v, mem_m[3]);
    rd(20, 0, v, oe);
    chk(v == 16'hFFFF, "R5 program during erase ignored", v, 16'hFFFF);

    // R6 / R8 suspend and resume
    do_pgm(17, 16'h1234, 1, 0, 1, c0);
    do_pgm(9, 16'hABCD, 1, 0, 1, c0);
    do_erase(18, 0, c0);
    e = stat(tog_m, tog_m);
    rd(17, 0, v, oe);
    chk(v == e, "R7 erase status toggling", v, e);
    wr(11'd0, 16'h00B0);
    cs = cyc;
    k = cs - c0 - 1;
    chk(ry_by == 1'b1, "R6 ready in suspend", 32'(ry_by), 1);
    e = stat(1'b1, tog_m);
    rd(17, 0, v, oe);
    chk(v == e, "R8 suspended sector status", v, e);
    rd(9, 0, v, oe);
    chk(v == 16'hABCD, "R8 other sector data", v, 16'hABCD);
    do_pgm(10, 16'h0FF0, 1, 0, 1, c0);
    rd(10, 0, v, oe);
    chk(v == mem_m[10], "R8 program in suspend", v, mem_m[10]);
    unlock3(8'hA0); wr(11'd19, 16'h0000);
    chk(ry_by == 1'b1, "R8 program to suspended sector ignored", 32'(ry_by), 1);
    wr(11'd0, 16'h0030);
    c0 = cyc;
    chk(ry_by == 1'b0, "R6 resume busy", 32'(ry_by), 0);
    wait_ready(c0, n);
    chk(n == ERS - k, "R6 remaining erase cycles", 32'(n), 32'(ERS - k));
    for (int i = 16; i < 24; i++) mem_m[i] = 16'hFFFF;
    rd(19, 0, v, oe);
    chk(v == 16'hFFFF, "R6 erase finished after resume", v, 16'hFFFF);

    // R3 chip erase
    do_erase(0, 1, c0);
    wait_ready(c0, n);
    chk(n == ERS, "R3 chip erase busy length", 32'(n), 32'(ERS));
    for (int i = 0; i < DEPTH; i++) mem_m[i] = 16'hFFFF;
    for (int i = 0; i < DEPTH; i += 5) begin
      rd(i, 0, v, oe);
      chk(v == 16'hFFFF, "R3 chip erased", v, 16'hFFFF);
    end

    // random mix
    for (int it = 0; it < 40; it++) begin
      idx = $urandom_range(DEPTH - 1);
      wm = 1'($urandom);
      lane = $urandom_range(1);
      sel = $urandom_range(3);
      if (sel < 3) do_pgm(idx, 16'($urandom), wm, 1'(lane), 1, c0);
      else begin
        wr(11'h555, 16'h00AA); wr(11'h555, 16'h0055); wr(11'h555, 16'h00A0);
        wr(AW'(idx), 16'h0000);
        chk(ry_by == 1'b1, "R4 random broken sequence", 32'(ry_by), 1);
      end
      idx = $urandom_range(DEPTH - 1);
      wm = 1'($urandom);
      lane = $urandom_range(1);
      word_mode = wm;
      e = exp_rd(idx, wm, 1'(lane));
      rd(idx, 1'(lane), v, oe);
      chk(v == e, "R9 R10 random readback", v, e);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule